// File: doc/BRIEF.md
# Sticky Global Error Collector

This block gathers error reports from a fixed set of local sources and keeps them at two levels. Each accepted report first sets a per-source, per-severity bit in a local status register. It then reaches the global status register, either directly for sources wired straight to the global logic, or only when the severity's routing enable is set for sources that pass through the collector. One system-event output per severity is raised while any global bit of that severity is set and that severity is unmasked.

Reports arrive as a valid/ready stream that carries a severity code and a source number. The block has no buffer. Ready stays high except while either reset input is asserted. A report counts only in a cycle where valid and ready are both high, and a sender that sees ready low holds its report. Both status registers are sticky. A hard reset leaves them alone and clears only the routing-enable and mask registers. Software clears status by writing ones, and a power-on reset clears everything. A small register port reads all four registers and writes them, with write-one-to-clear on the status registers.

Top module: `glb_err_collector`

## Requirements
- R1: `err_ready` is low while `hard_rst` or `por_rst` is high and high otherwise. While it is low, reports and register writes have no effect.
- R2: An accepted report with severity code 0 (correctable), 1 (non-fatal) or 2 (fatal) from source s < N_SRC sets local status bit 3*s+code in the next cycle, whatever the routing enables hold.
- R3: Sources numbered below N_DIRECT set global status bit 3*s+code on every accepted report. Other sources set it only when routing-enable bit `code` (address 0, bits 2:0) is 1 in the cycle the report is accepted.
- R4: Writing to address 2 (global status) or address 3 (local status) clears each bit whose write-data bit is 1 and leaves the bits where it is 0 unchanged.
- R5: If a report sets a status bit in the same cycle that software clears that bit, the bit ends up set.
- R6: `sys_evt[k]` is 1 exactly when some global status bit of severity k is set and mask bit k (address 1, bits 2:0) is 1.
- R7: A hard reset keeps both status registers and clears the routing-enable and mask registers to 0.
- R8: A power-on reset clears both status registers, the routing enables and the mask.
- R9: A report with severity code 3, or with a source number of N_SRC or more, changes no state.
- R10: Reads return routing enables at address 0, mask at 1, global status at 2 and local status at 3, all zero-extended. Writes to addresses 0 and 1 load bits 2:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Hard reset, synchronous, active high; status kept |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears all |
| err_valid | input | 1 | Error report present |
| err_ready | output | 1 | Report can be taken this cycle |
| err_sev | input | 2 | Severity code: 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| err_src | input | SRC_W | Reporting source number |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from address |
| sys_evt | output | 3 | System event per severity |

## Verification
The hardest case to reach is a report that lands in the same cycle as a clear of the very bit it sets, on a source that is gated by its enable. Random traffic rarely lines up source, severity, enable and write data like this, so directed steps set up each collision on purpose. The random phase also mixes rare hard resets into live traffic, which checks that status survives while the enable and mask registers start over.

// File: rtl/glb_err_pkg.sv
package glb_err_pkg;
  localparam int unsigned NUM_SEV = 3;

  typedef enum logic [1:0] {
    SEV_COR  = 2'd0,
    SEV_NF   = 2'd1,
    SEV_FAT  = 2'd2,
    SEV_RSVD = 2'd3
  } sev_e;

  typedef enum logic [1:0] {
    REG_ROUTE_EN = 2'd0,
    REG_EVT_MASK = 2'd1,
    REG_GLB_STAT = 2'd2,
    REG_LOC_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/glb_err_sticky_bank.sv
module glb_err_sticky_bank #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] state_q
);
  // Only power-on reset touches these bits; a set outranks a clear.
  always_ff @(posedge clk) begin
    if (por_rst) state_q <= '0;
    else         state_q <= (state_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/glb_err_ctrl_regs.sv
module glb_err_ctrl_regs #(
  parameter int unsigned NSEV = 3
) (
  input  logic            clk,
  input  logic            por_rst,
  input  logic            hard_rst,
  input  logic            wr_route,
  input  logic            wr_mask,
  input  logic [NSEV-1:0] wdata,
  output logic [NSEV-1:0] route_en_q,
  output logic [NSEV-1:0] evt_mask_q
);
  // Plain control state: either reset clears it.
  always_ff @(posedge clk) begin
    if (por_rst || hard_rst) begin
      route_en_q <= '0;
      evt_mask_q <= '0;
    end else begin
      if (wr_route) route_en_q <= wdata;
      if (wr_mask)  evt_mask_q <= wdata;
    end
  end
endmodule

// File: rtl/glb_err_event_map.sv
module glb_err_event_map #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned NSEV  = 3
) (
  input  logic [NSEV*N_SRC-1:0] glb_stat,
  input  logic [NSEV-1:0]       evt_mask,
  output logic [NSEV-1:0]       sys_evt
);
  for (genvar v = 0; v < NSEV; v++) begin : g_sev
    logic [N_SRC-1:0] column;
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign column[s] = glb_stat[s*NSEV+v];
    end
    assign sys_evt[v] = (|column) & evt_mask[v];
  end
endmodule

// File: rtl/glb_err_collector.sv
module glb_err_collector
  import glb_err_pkg::*;
#(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned N_DIRECT = 1,
  parameter int unsigned SRC_W    = 3,
  parameter int unsigned DATA_W   = 32
) (
  input  logic               clk,
  input  logic               hard_rst,
  input  logic               por_rst,
  input  logic               err_valid,
  output logic               err_ready,
  input  logic [1:0]         err_sev,
  input  logic [SRC_W-1:0]   err_src,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_SEV-1:0] sys_evt
);
  localparam int unsigned ST_W = NUM_SEV * N_SRC;

  logic              any_rst, accept, wr_ok;
  logic [ST_W-1:0]   loc_set, glb_set, loc_clr, glb_clr;
  logic [ST_W-1:0]   loc_q, glb_q;
  logic [NUM_SEV-1:0] route_en_q, evt_mask_q;
  logic              unused_wdata;

  assign any_rst   = hard_rst | por_rst;
  assign err_ready = ~any_rst;
  assign accept    = err_valid & err_ready & (err_sev != SEV_RSVD)
                   & ({1'b0, err_src} < (SRC_W+1)'(N_SRC));
  assign wr_ok     = reg_we & ~any_rst;

  // Decode each accepted report to its bit; gate collector-routed sources.
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    for (genvar v = 0; v < NUM_SEV; v++) begin : g_sev
      assign loc_set[s*NUM_SEV+v] = accept && (err_src == SRC_W'(s)) && (err_sev == 2'(v));
      if (s < N_DIRECT) begin : g_direct
        assign glb_set[s*NUM_SEV+v] = loc_set[s*NUM_SEV+v];
      end else begin : g_routed
        assign glb_set[s*NUM_SEV+v] = loc_set[s*NUM_SEV+v] & route_en_q[v];
      end
    end
  end

  assign glb_clr = (wr_ok && reg_addr == REG_GLB_STAT) ? reg_wdata[ST_W-1:0] : '0;
  assign loc_clr = (wr_ok && reg_addr == REG_LOC_STAT) ? reg_wdata[ST_W-1:0] : '0;
  assign unused_wdata = ^reg_wdata;

  glb_err_sticky_bank #(.WIDTH(ST_W)) u_loc (
    .clk(clk), .por_rst(por_rst), .set_vec(loc_set), .clr_vec(loc_clr), .state_q(loc_q)
  );

  glb_err_sticky_bank #(.WIDTH(ST_W)) u_glb (
    .clk(clk), .por_rst(por_rst), .set_vec(glb_set), .clr_vec(glb_clr), .state_q(glb_q)
  );

  glb_err_ctrl_regs #(.NSEV(NUM_SEV)) u_ctrl (
    .clk(clk), .por_rst(por_rst), .hard_rst(hard_rst),
    .wr_route(wr_ok && reg_addr == REG_ROUTE_EN),
    .wr_mask (wr_ok && reg_addr == REG_EVT_MASK),
    .wdata(reg_wdata[NUM_SEV-1:0]),
    .route_en_q(route_en_q), .evt_mask_q(evt_mask_q)
  );

  glb_err_event_map #(.N_SRC(N_SRC), .NSEV(NUM_SEV)) u_evt (
    .glb_stat(glb_q), .evt_mask(evt_mask_q), .sys_evt(sys_evt)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_ROUTE_EN: reg_rdata[NUM_SEV-1:0] = route_en_q;
      REG_EVT_MASK: reg_rdata[NUM_SEV-1:0] = evt_mask_q;
      REG_GLB_STAT: reg_rdata[ST_W-1:0]    = glb_q;
      default:      reg_rdata[ST_W-1:0]    = loc_q;
    endcase
  end
endmodule

// File: rtl/glb_err_collector_sva.sv
module glb_err_collector_sva #(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned N_DIRECT = 1,
  parameter int unsigned SRC_W    = 3,
  parameter int unsigned NSEV     = 3
) (
  input logic                  clk,
  input logic                  hard_rst,
  input logic                  por_rst,
  input logic                  err_valid,
  input logic                  err_ready,
  input logic [1:0]            err_sev,
  input logic [SRC_W-1:0]      err_src,
  input logic                  reg_we,
  input logic [1:0]            reg_addr,
  input logic [NSEV*N_SRC-1:0] wdata_lo,
  input logic [NSEV*N_SRC-1:0] loc_q,
  input logic [NSEV*N_SRC-1:0] glb_q,
  input logic [NSEV-1:0]       route_en_q,
  input logic [NSEV-1:0]       evt_mask_q,
  input logic [NSEV-1:0]       sys_evt
);
  localparam int unsigned ST_W  = NSEV * N_SRC;
  localparam int unsigned IDX_W = (ST_W > 1) ? $clog2(ST_W) : 1;

  logic             acc_c, sev_en, routed;
  logic [IDX_W-1:0] idx;

  always_comb begin
    acc_c  = err_valid && err_ready && (err_sev != 2'd3) && ({1'b0, err_src} < (SRC_W+1)'(N_SRC));
    idx    = IDX_W'(int'(err_src) * int'(NSEV) + int'(err_sev));
    sev_en = 1'b0;
    for (int v = 0; v < int'(NSEV); v++) if (err_sev == 2'(v)) sev_en = route_en_q[v];
    routed = ({1'b0, err_src} < (SRC_W+1)'(N_DIRECT)) || sev_en;
  end

  p_ready_low_r1: assert property (@(posedge clk) disable iff (por_rst)
    hard_rst |-> !err_ready);
  p_ready_high_r1: assert property (@(posedge clk) disable iff (por_rst)
    !hard_rst |-> err_ready);
  p_local_set_r2: assert property (@(posedge clk) disable iff (por_rst)
    acc_c |=> loc_q[$past(idx)]);
  p_gated_r3: assert property (@(posedge clk) disable iff (por_rst)
    (acc_c && !routed && !glb_q[idx] && !(reg_we && reg_addr == 2'd2)) |=> !glb_q[$past(idx)]);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (por_rst)
    (acc_c && routed && reg_we && reg_addr == 2'd2 && wdata_lo[idx]) |=> glb_q[$past(idx)]);
  p_sticky_r7: assert property (@(posedge clk) disable iff (por_rst)
    hard_rst |=> ($stable(glb_q) && $stable(loc_q) && route_en_q == '0 && evt_mask_q == '0));
  p_por_clear_r8: assert property (@(posedge clk)
    por_rst |=> (glb_q == '0 && loc_q == '0 && route_en_q == '0 && evt_mask_q == '0));
  for (genvar v = 0; v < NSEV; v++) begin : g_evt
    p_masked_r6: assert property (@(posedge clk) disable iff (por_rst)
      !evt_mask_q[v] |-> !sys_evt[v]);
  end
endmodule

bind glb_err_collector glb_err_collector_sva #(
  .N_SRC(N_SRC), .N_DIRECT(N_DIRECT), .SRC_W(SRC_W), .NSEV(glb_err_pkg::NUM_SEV)
) u_sva (
  .clk(clk), .hard_rst(hard_rst), .por_rst(por_rst), .err_valid(err_valid),
  .err_ready(err_ready), .err_sev(err_sev), .err_src(err_src), .reg_we(reg_we),
  .reg_addr(reg_addr), .wdata_lo(reg_wdata[ST_W-1:0]), .loc_q(loc_q), .glb_q(glb_q),
  .route_en_q(route_en_q), .evt_mask_q(evt_mask_q), .sys_evt(sys_evt)
);

// File: tb/glb_err_collector_test.sv
`timescale 1ns/1ps
module glb_err_collector_test;
  localparam int N_SRC = 4, N_DIRECT = 1, SRC_W = 3, DATA_W = 32;

  logic clk = 1'b0;
  logic hard_rst = 1'b0, por_rst = 1'b1;
  logic err_valid = 1'b0, err_ready;
  logic [1:0] err_sev = '0;
  logic [SRC_W-1:0] err_src = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
  logic [2:0] sys_evt;

  int checks = 0, errors = 0;
  logic [11:0] m_loc = '0, m_glb = '0;
  logic [2:0]  m_en = '0, m_mask = '0;

  always #2.5 clk = ~clk;

  glb_err_collector #(.N_SRC(N_SRC), .N_DIRECT(N_DIRECT), .SRC_W(SRC_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .hard_rst(hard_rst), .por_rst(por_rst), .err_valid(err_valid),
    .err_ready(err_ready), .err_sev(err_sev), .err_src(err_src), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_evt(sys_evt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_evt();
    logic [2:0] e = '0;
    for (int s = 0; s < N_SRC; s++)
      for (int v = 0; v < 3; v++) if (m_glb[s*3+v]) e[v] = 1'b1;
    return e & m_mask;
  endfunction

  function automatic logic [31:0] exp_reg(input logic [1:0] a);
    case (a)
      2'd0: return {29'd0, m_en};
      2'd1: return {29'd0, m_mask};
      2'd2: return {20'd0, m_glb};
      default: return {20'd0, m_loc};
    endcase
  endfunction

  task automatic step(input logic v, input logic [1:0] sev, input logic [2:0] src,
                      input logic we, input logic [1:0] a, input logic [31:0] wd,
                      input logic hr, input logic pr, input string req);
    logic acc;
    logic [11:0] bitv;
    @(negedge clk);
    err_valid = v; err_sev = sev; err_src = src;
    reg_we = we; reg_addr = a; reg_wdata = wd; hard_rst = hr; por_rst = pr;
    #1 chk(err_ready === !(hr | pr), "R1", {31'd0, err_ready}, {31'd0, !(hr | pr)});
    @(posedge clk);
    if (pr) begin
      m_loc = '0; m_glb = '0; m_en = '0; m_mask = '0;
    end else if (hr) begin
      m_en = '0; m_mask = '0;
    end else begin
      acc  = v && sev != 2'd3 && src < N_SRC;
      bitv = acc ? (12'd1 << (src * 3 + sev)) : 12'd0;
      if (we && a == 2'd2) m_glb = m_glb & ~wd[11:0];
      if (we && a == 2'd3) m_loc = m_loc & ~wd[11:0];
      m_loc = m_loc | bitv;
      if (src < N_DIRECT || (acc && m_en[sev])) m_glb = m_glb | bitv;
      if (we && a == 2'd0) m_en = wd[2:0];
      if (we && a == 2'd1) m_mask = wd[2:0];
    end
    #1 chk(sys_evt === exp_evt(), {req, "/R6"}, {29'd0, sys_evt}, {29'd0, exp_evt()});
  endtask

  task automatic idle_peek(input string req);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      err_valid = 0; reg_we = 0; hard_rst = 0; por_rst = 0; reg_addr = 2'(a);
      #1 chk(reg_rdata === exp_reg(2'(a)), {req, "/R10"}, reg_rdata, exp_reg(2'(a)));
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    idle_peek("R8 reset state");
    // R3: gated source with enables off reaches local only
    step(1, 2'd1, 3'd2, 0, 0, 0, 0, 0, "R3");
    idle_peek("R2/R3 gated");
    // R3: direct source bypasses enables
    step(1, 2'd2, 3'd0, 0, 0, 0, 0, 0, "R3");
    idle_peek("R3 direct");
    // enable all, unmask all
    step(0, 0, 0, 1, 2'd0, 32'h7, 0, 0, "R10");
    step(0, 0, 0, 1, 2'd1, 32'h7, 0, 0, "R6");
    step(1, 2'd0, 3'd3, 0, 0, 0, 0, 0, "R6");
    idle_peek("R6 routed");
    // R5: set and clear of bit 9 together
    step(1, 2'd0, 3'd3, 1, 2'd2, 32'h200, 0, 0, "R5");
    step(1, 2'd0, 3'd3, 1, 2'd3, 32'h200, 0, 0, "R5");
    idle_peek("R5 set wins");
    // R4: zeros do nothing, ones clear
    step(0, 0, 0, 1, 2'd2, 32'h0, 0, 0, "R4");
    idle_peek("R4 zero write");
    step(0, 0, 0, 1, 2'd2, 32'h200, 0, 0, "R4");
    idle_peek("R4 one write");
    // R9: reserved severity and out-of-range sources
    step(1, 2'd3, 3'd1, 0, 0, 0, 0, 0, "R9");
    step(1, 2'd0, 3'd5, 0, 0, 0, 0, 0, "R9");
    step(1, 2'd2, 3'd7, 0, 0, 0, 0, 0, "R9");
    idle_peek("R9 ignored");
    // R7/R1: hard reset with traffic and a write attempt
    step(1, 2'd1, 3'd1, 1, 2'd3, 32'hFFF, 1, 0, "R7");
    step(1, 2'd2, 3'd2, 0, 0, 0, 1, 0, "R1");
    idle_peek("R7 sticky");
    // random phase
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 3) != 0, 2'($urandom % 4), 3'($urandom % 8),
           ($urandom % 4) == 0, 2'($urandom % 4), $urandom,
           ($urandom % 60) == 0, ($urandom % 250) == 0, "R2");
      if (i % 20 == 19) idle_peek("R4 random");
    end
    // R8: power-on reset after errors are logged
    step(1, 2'd0, 3'd0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    idle_peek("R8 por clear");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule